// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller with Status Nesting Stack

This block sits beside the program sequencer of a small processor core. It gathers seven interrupt sources, decides which pending one should be serviced, and offers the core the vector address of that winner. Software reaches it through a small register write port. That port holds three things: a mask, a global enable, and a write-only register that can force or clear each edge-type request.

When the core takes the offered interrupt, the controller saves the arithmetic status word, the mode status word and the current mask as one entry on a dedicated seven-entry stack. It then loads a new mask from a saved-mask input, which lets the interrupt service routine block lower-priority sources while it runs. A return-from-interrupt strobe pops the top entry. The popped mask goes back into the mask register, and the two popped status words are handed back to the core.

Two of the seven source slots are shared. A configuration input chooses whether each is fed by its serial-port request or by an external pin. Slot 0 is the non-maskable reset source, and taking it wipes the controller's pending state, mask and stack.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release with no stimulus, `irq_req_o`, `mask_o`, `depth_o`, `ovf_o`, `unf_o` and `restore_vld_o` are all 0, and the global enable is off.
- R2: The vector of slot k is 4*k. The slots, in order, are: 0 reset, 1 external request 2, 2 serial port 0 transmit, 3 serial port 0 receive, 4 serial port 1 transmit or external request 1, 5 serial port 1 receive or external request 0, and 6 timer.
- R3: A slot is eligible when it is pending, its mask bit is set and the global enable is on. Slot 0 is eligible whenever pending, whatever the mask or enable. `irq_req_o` is high when any slot is eligible, and `vec_o` then shows the vector of the eligible slot with the lowest index. Register writes use `wr_sel_i`: 0 writes the mask from `wr_data_i[6:0]`, 1 writes force/clear, and 2 writes the global enable from `wr_data_i[0]`.
- R4: An edge-type slot becomes pending on a rising edge of its request line. It stays pending after the line falls, until it is taken or cleared.
- R5: In a force/clear write, `wr_data_i[k]` forces slot k and `wr_data_i[7+k]` clears slot k. If both bits are set for the same slot, the clear wins.
- R6: For a slot whose `level_sel_i` bit is 1, the pending state follows its request line. Force and clear writes to that slot have no effect, and taking it does not clear it. Slot 0 always behaves this way.
- R7: When `pin_mode_i` is 1, slots 4 and 5 are fed by `alt_req_i[1]` and `alt_req_i[0]`, and `src_req_i[4]` and `src_req_i[5]` are ignored. When it is 0, the reverse holds.
- R8: Acceptance happens in a cycle where `take_i` and `irq_req_o` are both high and the winner is not slot 0. The winning edge-type pending bit is cleared. `{astat_i, mstat_i, mask}` is pushed, `depth_o` rises by one, and `mask_o` becomes `new_mask_i`.
- R9: A pulse on `rti_i` while the stack is not empty pops the top entry. On the next cycle `mask_o`, `astat_o` and `mstat_o` hold the popped values, `restore_vld_o` is high for one cycle, and `depth_o` falls by one.
- R10: The stack holds 7 entries. A push when 7 are held sets the sticky flag `ovf_o` and leaves the stack untouched, but the interrupt is still accepted. Later pops return the 7 earlier entries in last-in, first-out order.
- R11: A pop on an empty stack sets the sticky flag `unf_o`. It changes neither the mask nor the depth, and it raises no `restore_vld_o`.
- R12: Taking slot 0 clears every pending bit, the mask and the stack depth, and it pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | 7 | Native request line per slot |
| alt_req_i | input | 2 | External request lines for slot 4 (bit 1) and slot 5 (bit 0) |
| pin_mode_i | input | 1 | 1: slots 4 and 5 are fed by the external pins |
| level_sel_i | input | 7 | 1: the slot is level-sensitive |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 mask, 1 force/clear, 2 enable |
| wr_data_i | input | 14 | Register write data |
| irq_req_o | output | 1 | An eligible interrupt is offered |
| vec_o | output | 16 | Vector address of the winner |
| take_i | input | 1 | Core accepts the offered interrupt |
| new_mask_i | input | 7 | Mask to load on acceptance |
| astat_i | input | 16 | Arithmetic status word to save |
| mstat_i | input | 16 | Mode status word to save |
| rti_i | input | 1 | Return-from-interrupt strobe |
| astat_o | output | 16 | Restored arithmetic status word |
| mstat_o | output | 16 | Restored mode status word |
| restore_vld_o | output | 1 | Restored words are valid this cycle |
| mask_o | output | 7 | Current mask |
| depth_o | output | 3 | Entries held on the stack |
| ovf_o | output | 1 | Sticky stack overflow flag |
| unf_o | output | 1 | Sticky stack underflow flag |

## Verification
The arbiter is exercised exhaustively. The bench forces every one of the 64 combinations of pending slots 1 to 6 and pairs each with all 64 masks. This separates a correct lowest-index choice from an off-by-one priority, from a mask that is ignored, and from a wrong vector step. Further directed patterns cover the other behaviours:
- a single-cycle edge pulse that must stay latched;
- a force and a clear of the same slot, which must cancel;
- a level-sensitive slot that must refuse forcing and survive being taken;
- both settings of the shared-slot selection.

A run of eight nested takes and eight returns uses a distinct mask and status pair at each level. It shows that stack ordering is correct, that overflow drops only the extra entry, and that underflow leaves the state alone. Taking the reset slot at the end confirms the wipe.

// File: rtl/irqc_pkg.sv
// Package: shared constants and types of the vectored interrupt controller.
// Assumes the source count is at least six, so that the shared slots exist.
package irqc_pkg;
    // Register select codes on the write port.
    typedef enum logic [1:0] {
        WSEL_MASK = 2'd0,
        WSEL_FC   = 2'd1,
        WSEL_GEN  = 2'd2,
        WSEL_NONE = 2'd3
    } wsel_e;

    // Slot that carries the non-maskable reset request.
    localparam int SLOT_RESET = 0;
    // Slots that can be switched between serial-port and pin requests.
    localparam int SLOT_SHR_A = 4;
    localparam int SLOT_SHR_B = 5;
endpackage

// File: rtl/irqc_pending.sv
// Module: irqc_pending
// Holds one pending bit per interrupt slot. An edge-type slot latches a rising
// edge of its line and keeps it until it is taken or cleared. A level-type slot
// simply presents its line. Assumes force and clear arrive already decoded and
// that take_clr_i is one-hot or zero.
module irqc_pending #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] line_i,
    input  logic [NUM_SRC-1:0] level_i,
    input  logic [NUM_SRC-1:0] force_i,
    input  logic [NUM_SRC-1:0] clear_i,
    input  logic [NUM_SRC-1:0] take_clr_i,
    input  logic               wipe_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] latch_q;
    logic [NUM_SRC-1:0] latch_d;

    // Next latch state: sets win over nothing, and clears win over sets.
    always_comb begin
        latch_d = (latch_q | (line_i & ~prev_q) | force_i) & ~clear_i & ~take_clr_i;
        latch_d = latch_d & ~level_i;
        if (wipe_i) latch_d = '0;
    end

    // Register the line history and the latched edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= line_i;
            latch_q <= latch_d;
        end
    end

    // Present the level lines directly and the latched edges otherwise.
    always_comb pend_o = (level_i & line_i) | (~level_i & latch_q);

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
            // R5
            fc_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (force_i[i] && clear_i[i]) |=> !latch_q[i]);
        end
    endgenerate
endmodule

// File: rtl/irqc_arbiter.sv
// Module: irqc_arbiter
// Fixed-priority selection: the lowest eligible slot index wins, and its vector
// is index times VEC_STEP. The reset slot bypasses the mask and the global enable.
// clk and rst_n are used only by the checks.
module irqc_arbiter #(
    parameter int NUM_SRC  = 7,
    parameter int VEC_W    = 16,
    parameter int VEC_STEP = 4,
    localparam int IW      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic               gen_i,
    output logic               valid_o,
    output logic [IW-1:0]      win_o,
    output logic [NUM_SRC-1:0] win_oh_o,
    output logic [VEC_W-1:0]   vec_o
);
    localparam logic [NUM_SRC-1:0] NMI_BITS = NUM_SRC'(1) << irqc_pkg::SLOT_RESET;

    logic [NUM_SRC-1:0] elig;

    // Work out which slots may be serviced right now.
    always_comb elig = pend_i & ((mask_i & {NUM_SRC{gen_i}}) | NMI_BITS);

    // Scan from the lowest priority upward, so the lowest index is kept last.
    always_comb begin
        win_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) win_o = IW'(i);
        end
        valid_o  = |elig;
        win_oh_o = valid_o ? (NUM_SRC'(1) << win_o) : '0;
        vec_o    = valid_o ? VEC_W'(VEC_STEP * int'(win_o)) : '0;
    end

    // R3
    arb_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (elig[win_o] && ((elig & ((NUM_SRC'(1) << win_o) - NUM_SRC'(1))) == '0)));
endmodule

// File: rtl/irqc_stack.sv
// Module: irqc_stack
// Bounded last-in, first-out store for the saved status entries. A push wins
// over a simultaneous pop. A push when full or a pop when empty sets a sticky
// flag and leaves the contents alone. wipe_i empties the stack.
module irqc_stack #(
    parameter int W      = 39,
    parameter int DEPTH  = 7,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             wipe_i,
    input  logic [W-1:0]     din_i,
    output logic [W-1:0]     top_o,
    output logic             empty_o,
    output logic [PTR_W-1:0] level_o,
    output logic             ovf_o,
    output logic             unf_o
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] level_q;
    logic             full;

    // Decode the occupancy.
    always_comb begin
        full    = (level_q == PTR_W'(DEPTH));
        empty_o = (level_q == '0);
    end

    // Store a new entry at the free location.
    always_ff @(posedge clk) begin
        if (push_i && !full && !wipe_i) mem[IDX_W'(level_q)] <= din_i;
    end

    // Track the occupancy and the sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            ovf_o   <= 1'b0;
            unf_o   <= 1'b0;
        end else if (wipe_i) begin
            level_q <= '0;
        end else if (push_i) begin
            if (full) ovf_o   <= 1'b1;
            else      level_q <= level_q + PTR_W'(1);
        end else if (pop_i) begin
            if (empty_o) unf_o   <= 1'b1;
            else         level_q <= level_q - PTR_W'(1);
        end
    end

    // Show the entry on top, or zero when nothing is held.
    always_comb top_o = empty_o ? '0 : mem[IDX_W'(level_q - PTR_W'(1))];

    assign level_o = level_q;

    // R8
    stk_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full && !wipe_i) |=> (level_q == $past(level_q) + PTR_W'(1)));
    // R9
    stk_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o && !wipe_i) |=> (level_q == $past(level_q) - PTR_W'(1)));
    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
    // R11
    unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o && !wipe_i) |=> (unf_o && level_q == '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
// Module: vec_irq_ctrl
// Top of the vectored interrupt controller. It selects the shared-slot sources,
// decodes register writes, accepts interrupts on the take strobe, saves and
// restores status through the nesting stack, and loads the new mask.
// Assumes the core raises take_i only while irq_req_o is high, and that rti_i
// and take_i do not coincide; if they do, the take wins and the pop is dropped.
module vec_irq_ctrl #(
    parameter int NUM_SRC  = 7,
    parameter int SW       = 16,
    parameter int VEC_W    = 16,
    parameter int VEC_STEP = 4,
    parameter int DEPTH    = 7,
    localparam int PTR_W   = $clog2(DEPTH + 1),
    localparam int ENT_W   = 2 * SW + NUM_SRC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_req_i,
    input  logic [1:0]           alt_req_i,
    input  logic                 pin_mode_i,
    input  logic [NUM_SRC-1:0]   level_sel_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_sel_i,
    input  logic [2*NUM_SRC-1:0] wr_data_i,
    output logic                 irq_req_o,
    output logic [VEC_W-1:0]     vec_o,
    input  logic                 take_i,
    input  logic [NUM_SRC-1:0]   new_mask_i,
    input  logic [SW-1:0]        astat_i,
    input  logic [SW-1:0]        mstat_i,
    input  logic                 rti_i,
    output logic [SW-1:0]        astat_o,
    output logic [SW-1:0]        mstat_o,
    output logic                 restore_vld_o,
    output logic [NUM_SRC-1:0]   mask_o,
    output logic [PTR_W-1:0]     depth_o,
    output logic                 ovf_o,
    output logic                 unf_o
);
    import irqc_pkg::*;

    localparam int IW = $clog2(NUM_SRC);
    localparam logic [NUM_SRC-1:0] NMI_BITS = NUM_SRC'(1) << SLOT_RESET;

    logic [NUM_SRC-1:0] line;
    logic [NUM_SRC-1:0] lvl_eff;
    logic [NUM_SRC-1:0] force_v;
    logic [NUM_SRC-1:0] clear_v;
    logic [NUM_SRC-1:0] take_clr;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] win_oh;
    logic [IW-1:0]      win_idx;
    logic               gen_q;
    logic               valid;
    logic               accept;
    logic               rst_take;
    logic               norm_take;
    logic               do_pop;
    logic               stk_empty;
    logic [ENT_W-1:0]   stk_top;
    logic [ENT_W-1:0]   stk_din;
    wsel_e              wsel;

    // Route the shared slots to either the serial-port or the pin request.
    always_comb begin
        line = src_req_i;
        if (pin_mode_i) begin
            line[SLOT_SHR_A] = alt_req_i[1];
            line[SLOT_SHR_B] = alt_req_i[0];
        end
    end

    // The reset slot is always level-sensitive.
    always_comb lvl_eff = level_sel_i | NMI_BITS;

    // Decode a force/clear write; level slots do not take part.
    always_comb begin
        wsel    = wsel_e'(wr_sel_i);
        force_v = '0;
        clear_v = '0;
        if (wr_en_i && wsel == WSEL_FC) begin
            force_v = wr_data_i[NUM_SRC-1:0] & ~lvl_eff;
            clear_v = wr_data_i[2*NUM_SRC-1:NUM_SRC] & ~lvl_eff;
        end
    end

    // Classify an acceptance as a reset take or a normal take.
    always_comb begin
        accept    = take_i && valid;
        rst_take  = accept && win_oh[SLOT_RESET];
        norm_take = accept && !win_oh[SLOT_RESET];
        take_clr  = norm_take ? (win_oh & ~lvl_eff) : '0;
        do_pop    = rti_i && !accept;
        stk_din   = {astat_i, mstat_i, mask_q};
    end

    irqc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line),
        .level_i    (lvl_eff),
        .force_i    (force_v),
        .clear_i    (clear_v),
        .take_clr_i (take_clr),
        .wipe_i     (rst_take),
        .pend_o     (pend)
    );

    irqc_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .mask_i   (mask_q),
        .gen_i    (gen_q),
        .valid_o  (valid),
        .win_o    (win_idx),
        .win_oh_o (win_oh),
        .vec_o    (vec_o)
    );

    irqc_stack #(.W(ENT_W), .DEPTH(DEPTH)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (norm_take),
        .pop_i   (do_pop),
        .wipe_i  (rst_take),
        .din_i   (stk_din),
        .top_o   (stk_top),
        .empty_o (stk_empty),
        .level_o (depth_o),
        .ovf_o   (ovf_o),
        .unf_o   (unf_o)
    );

    // Mask register: a take overrides a return, which overrides a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (rst_take) begin
            mask_q <= '0;
        end else if (norm_take) begin
            mask_q <= new_mask_i;
        end else if (do_pop && !stk_empty) begin
            mask_q <= stk_top[NUM_SRC-1:0];
        end else if (wr_en_i && wsel == WSEL_MASK) begin
            mask_q <= wr_data_i[NUM_SRC-1:0];
        end
    end

    // Global enable, written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                             gen_q <= 1'b0;
        else if (wr_en_i && wsel == WSEL_GEN)   gen_q <= wr_data_i[0];
    end

    // Hand the popped status words back to the core for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            astat_o       <= '0;
            mstat_o       <= '0;
            restore_vld_o <= 1'b0;
        end else begin
            restore_vld_o <= do_pop && !stk_empty && !rst_take;
            if (do_pop && !stk_empty && !rst_take) begin
                astat_o <= stk_top[ENT_W-1 -: SW];
                mstat_o <= stk_top[NUM_SRC +: SW];
            end
        end
    end

    assign irq_req_o = valid;
    assign mask_o    = mask_q;

    // R8
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && irq_req_o && vec_o != '0) |=> (mask_o == $past(new_mask_i)));
    // R12
    reset_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && irq_req_o && vec_o == '0) |=> (mask_o == '0 && depth_o == '0));
    // R9
    restore_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_vld_o |=> !restore_vld_o || $past(rti_i));
endmodule

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module vec_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  src_req_i = '0;
    logic [1:0]  alt_req_i = '0;
    logic        pin_mode_i = 1'b0;
    logic [6:0]  level_sel_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [13:0] wr_data_i = '0;
    logic        irq_req_o;
    logic [15:0] vec_o;
    logic        take_i = 1'b0;
    logic [6:0]  new_mask_i = '0;
    logic [15:0] astat_i = '0;
    logic [15:0] mstat_i = '0;
    logic        rti_i = 1'b0;
    logic [15:0] astat_o;
    logic [15:0] mstat_o;
    logic        restore_vld_o;
    logic [6:0]  mask_o;
    logic [2:0]  depth_o;
    logic        ovf_o;
    logic        unf_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vec_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req_i), .alt_req_i(alt_req_i),
        .pin_mode_i(pin_mode_i), .level_sel_i(level_sel_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .irq_req_o(irq_req_o),
        .vec_o(vec_o), .take_i(take_i), .new_mask_i(new_mask_i), .astat_i(astat_i),
        .mstat_i(mstat_i), .rti_i(rti_i), .astat_o(astat_o), .mstat_o(mstat_o),
        .restore_vld_o(restore_vld_o), .mask_o(mask_o), .depth_o(depth_o),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [13:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic take(input logic [15:0] a, input logic [15:0] m, input logic [6:0] nm);
        @(negedge clk);
        take_i = 1'b1; astat_i = a; mstat_i = m; new_mask_i = nm;
        @(negedge clk);
        take_i = 1'b0;
    endtask

    task automatic rti();
        @(negedge clk);
        rti_i = 1'b1;
        @(negedge clk);
        rti_i = 1'b0;
    endtask

    task automatic pulse_src(input int k);
        @(negedge clk);
        src_req_i[k] = 1'b1;
        @(negedge clk);
        src_req_i[k] = 1'b0;
    endtask

    function automatic logic [6:0] nest_mask(input int k);
        return 7'h40 | 7'((k & 31) << 1);
    endfunction

    function automatic logic [6:0] saved_mask(input int k);
        return (k == 0) ? 7'h7E : nest_mask(k - 1);
    endfunction

    localparam logic [13:0] CLR_ALL = 14'h3F80;

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state while held and after release
        check("R1 req in reset", 32'(irq_req_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req", 32'(irq_req_o), 0);
        check("R1 mask", 32'(mask_o), 0);
        check("R1 depth", 32'(depth_o), 0);
        check("R1 flags", {ovf_o, unf_o, restore_vld_o}, 0);
        wr(2'd1, 14'h007E);
        wr(2'd0, 14'h007E);
        check("R1 enable off", 32'(irq_req_o), 0);
        wr(2'd1, CLR_ALL);

        // R2 R3 exhaustive arbitration sweep
        wr(2'd2, 14'h0001);
        for (int p = 0; p < 64; p++) begin
            for (int m = 0; m < 64; m++) begin
                int e;
                int lo;
                wr(2'd1, CLR_ALL);
                wr(2'd1, 14'(p << 1));
                wr(2'd0, 14'(m << 1));
                e = p & m;
                lo = 0;
                for (int b = 5; b >= 0; b--) if (e[b]) lo = b + 1;
                check("R3 sweep req", 32'(irq_req_o), (e != 0) ? 1 : 0);
                check("R2 sweep vec", 32'(vec_o), (e != 0) ? 32'(4 * lo) : 0);
            end
        end
        wr(2'd1, CLR_ALL);

        // R4 edge latch survives line fall, then clear removes it
        wr(2'd0, 14'h0004);
        pulse_src(2);
        check("R4 edge latched", 32'(irq_req_o), 1);
        check("R4 vec", 32'(vec_o), 8);
        wr(2'd1, 14'h0004 << 7);
        check("R4 cleared", 32'(irq_req_o), 0);

        // R5 force and clear together: clear wins
        wr(2'd1, 14'h0004 | (14'h0004 << 7));
        check("R5 clear wins", 32'(irq_req_o), 0);

        // R6 level slot ignores force, follows line, survives take
        level_sel_i = 7'h08;
        wr(2'd0, 14'h0008);
        wr(2'd1, 14'h0008);
        check("R6 force ignored", 32'(irq_req_o), 0);
        @(negedge clk); src_req_i[3] = 1'b1;
        #1;
        check("R6 level vec", 32'(vec_o), 12);
        take(16'h0AAA, 16'h0BBB, 7'h08);
        check("R6 not cleared by take", 32'(irq_req_o), 1);
        check("R8 depth after level take", 32'(depth_o), 1);
        src_req_i[3] = 1'b0;
        #1;
        check("R6 follows line", 32'(irq_req_o), 0);
        rti();
        check("R9 level pop astat", 32'(astat_o), 32'h0AAA);
        check("R9 level pop mstat", 32'(mstat_o), 32'h0BBB);
        check("R9 level pop mask", 32'(mask_o), 32'h08);
        level_sel_i = '0;

        // R7 shared slot selection
        wr(2'd0, 14'h0010);
        pin_mode_i = 1'b1;
        @(negedge clk); alt_req_i[1] = 1'b1;
        @(negedge clk); alt_req_i[1] = 1'b0;
        check("R7 pin source", 32'(vec_o), 16);
        wr(2'd1, CLR_ALL);
        pulse_src(4);
        check("R7 native ignored", 32'(irq_req_o), 0);
        pin_mode_i = 1'b0;
        @(negedge clk);
        @(negedge clk); alt_req_i[1] = 1'b1;
        @(negedge clk); alt_req_i[1] = 1'b0;
        check("R7 pin ignored", 32'(irq_req_o), 0);
        pulse_src(4);
        check("R7 native source", 32'(vec_o), 16);
        wr(2'd1, CLR_ALL);

        // R8 R10 nesting to overflow
        wr(2'd0, 14'h007E);
        for (int k = 0; k < 8; k++) begin
            wr(2'd1, 14'h0040);
            check("R2 timer vec", 32'(vec_o), 24);
            take(16'(16'h0100 + k), 16'(16'h0200 + k), nest_mask(k));
            check("R8 pending cleared", 32'(irq_req_o), 0);
            check("R8 new mask", 32'(mask_o), 32'(nest_mask(k)));
            check("R10 depth", 32'(depth_o), (k < 7) ? 32'(k + 1) : 7);
            check("R10 ovf", 32'(ovf_o), (k < 7) ? 0 : 1);
        end

        // R9 R10 pops return the seven stored entries
        for (int i = 0; i < 7; i++) begin
            int k;
            k = 6 - i;
            rti();
            check("R9 vld", 32'(restore_vld_o), 1);
            check("R9 astat", 32'(astat_o), 32'(16'h0100 + k));
            check("R9 mstat", 32'(mstat_o), 32'(16'h0200 + k));
            check("R9 mask", 32'(mask_o), 32'(saved_mask(k)));
            check("R9 depth", 32'(depth_o), 32'(k));
            @(negedge clk);
            check("R9 vld one cycle", 32'(restore_vld_o), 0);
        end

        // R11 underflow
        rti();
        check("R11 unf", 32'(unf_o), 1);
        check("R11 no vld", 32'(restore_vld_o), 0);
        check("R11 mask kept", 32'(mask_o), 32'(saved_mask(0)));
        check("R11 depth", 32'(depth_o), 0);
        check("R10 ovf sticky", 32'(ovf_o), 1);

        // R12 reset slot take wipes state, works with enable off
        wr(2'd1, 14'h0040);
        take(16'h0001, 16'h0002, 7'h7E);
        wr(2'd1, 14'h0004);
        wr(2'd2, 14'h0000);
        @(negedge clk); src_req_i[0] = 1'b1;
        #1;
        check("R3 reset non-maskable", 32'(irq_req_o), 1);
        check("R2 reset vec", 32'(vec_o), 0);
        take(16'h0003, 16'h0004, 7'h7F);
        src_req_i[0] = 1'b0;
        #1;
        check("R12 mask cleared", 32'(mask_o), 0);
        check("R12 depth cleared", 32'(depth_o), 0);
        wr(2'd2, 14'h0001);
        wr(2'd0, 14'h007E);
        check("R12 pending cleared", 32'(irq_req_o), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule